// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a multiplexed bus that carries 32 address/data bits and 4 command/byte-enable bits. The parity bit covers all 36 of those bits. It is set so that those bits and the parity bit together hold an even number of ones. The surrounding bus controller tells the block which cycles carry an address phase or a data phase. It also tells the block whether this device is the initiator of the current transaction. The block does no arbitration and no transaction sequencing.

As initiator, the block drives the parity bit, with its output enable, in the clock after the address or data it covers. As observer or target, it takes the parity bit that arrives in that following clock. It compares that bit with parity computed from a registered copy of the earlier bus value. A mismatch on a data phase raises the parity-error strobe two clocks after the data phase. A mismatch on an address phase gives a single-clock system-error pulse at the same distance. Each report has its own enable bit in the command register.

Top module: `bus_parity_unit`

## Requirements
- R1: When `par_oe` is high, `par_out` equals the XOR of the 32 `bus_ad` bits and the 4 `bus_cbe` bits sampled one clock earlier. The 36 bits plus `par_out` then hold an even count of ones.
- R2: `par_oe` is high in exactly the clock after a cycle in which `is_initiator` was high and either `addr_phase` or `data_phase` was high. It is low in every other clock.
- R3: Take a data phase in cycle T with `is_initiator` low. If `par_in` in cycle T+1 differs from the even parity of the cycle-T bus bits, `perr_out` is high during cycle T+2.
- R4: `perr_out` is raised only if bit 6 of `cmd_reg` is 1 in cycle T+1. When that bit is 0, the mismatch leaves `perr_out` low.
- R5: Take an address phase in cycle T with `is_initiator` low. If the parity in cycle T+1 mismatches, `serr_out` is high during cycle T+2. This holds whether or not the device is the addressed target.
- R6: `serr_out` is raised only if bit 8 of `cmd_reg` is 1 in cycle T+1. When that bit is 0, the mismatch leaves `serr_out` low.
- R7: Each detected address parity error gives a `serr_out` pulse exactly one clock long. After an isolated error, `serr_out` is low again in cycle T+3.
- R8: In either kind of phase, a matching `par_in` leaves both `perr_out` and `serr_out` low.
- R9: While the device is initiator (`is_initiator` high in cycle T), no error is reported for that phase.
- R10: In the clock after a synchronous reset (`rst_n` low), `par_oe`, `perr_out` and `serr_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad | input | 32 | Multiplexed address/data bits seen on the bus |
| bus_cbe | input | 4 | Command / byte-enable bits seen on the bus |
| par_in | input | 1 | Parity bit received from the bus |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_phase | input | 1 | Current cycle is a data phase that completes |
| is_initiator | input | 1 | This device initiated the current transaction |
| cmd_reg | input | 16 | Command register; bit 6 enables data parity reports, bit 8 enables system-error reports |
| par_out | output | 1 | Parity bit to drive on the bus |
| par_oe | output | 1 | Output enable for `par_out` |
| perr_out | output | 1 | Data-phase parity error strobe, active high |
| serr_out | output | 1 | Address parity system-error pulse, active high |

## Verification
The assertions assume that `addr_phase` and `data_phase` are never high in the same cycle, since one bus cycle cannot be both. They also assume that `par_in` belongs to the phase of the cycle before. The stimulus raises only one phase qualifier at a time. It holds `cmd_reg` steady through each phase and the clock after it, and it sets `par_in` in the following clock from the bench's own bit count. An error is injected by inverting that bit. The sweep covers every phase kind, both roles, all four enable combinations, with and without injection, over a walking-one set of 36-bit patterns. A back-to-back address/data sequence then checks the pulse spacing.

// File: rtl/bpar_pkg.sv
// Package bpar_pkg
// Shared constants and the captured-phase record for the bus parity unit.
// Assumes the bus has one address/data field and one command field.
package bpar_pkg;
    localparam int unsigned DEF_AD_W      = 32;
    localparam int unsigned DEF_CBE_W     = 4;
    localparam int unsigned DEF_CMD_REG_W = 16;
    localparam int unsigned DEF_PERR_BIT  = 6;
    localparam int unsigned DEF_SERR_BIT  = 8;

    // Phase qualifiers as held for one clock after the bus cycle.
    typedef struct packed {
        logic addr;
        logic data;
        logic init;
    } phase_t;
endpackage

// File: rtl/bpar_xor_tree.sv
// Module bpar_xor_tree
// Reduces a vector to its even-parity bit in two levels: per-lane XOR,
// then XOR of the lane results. Purely combinational.
// Assumes WIDTH >= 1; the top lane is zero-padded when WIDTH is not a
// multiple of LANE_W.
module bpar_xor_tree #(
    parameter int unsigned WIDTH  = 36,
    parameter int unsigned LANE_W = 4
) (
    input  logic [WIDTH-1:0] vec_in,
    output logic             par_bit
);
    localparam int unsigned N_LANE = (WIDTH + LANE_W - 1) / LANE_W;
    localparam int unsigned PAD_W  = N_LANE * LANE_W;

    logic [PAD_W-1:0]  padded;
    logic [N_LANE-1:0] lane_par;

    // Zero-extend the input to a whole number of lanes.
    always_comb begin
        padded = '0;
        padded[WIDTH-1:0] = vec_in;
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        // First level: parity of one lane.
        assign lane_par[g] = ^padded[g*LANE_W +: LANE_W];
    end

    // Second level: combine lane parities.
    assign par_bit = ^lane_par;
endmodule

// File: rtl/bpar_capture.sv
// Module bpar_capture
// Registers the parity of the current bus value and the phase qualifiers,
// so that the following clock has both the generated parity and the
// context for checking the received bit.
// Assumes addr_phase and data_phase are mutually exclusive.
module bpar_capture
    import bpar_pkg::*;
#(
    parameter int unsigned AD_W  = DEF_AD_W,
    parameter int unsigned CBE_W = DEF_CBE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  bus_ad,
    input  logic [CBE_W-1:0] bus_cbe,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             is_initiator,
    output logic             par_q,
    output phase_t           phase_q
);
    localparam int unsigned COVER_W = AD_W + CBE_W;

    logic par_now;

    bpar_xor_tree #(
        .WIDTH  (COVER_W),
        .LANE_W (4)
    ) i_tree (
        .vec_in  ({bus_cbe, bus_ad}),
        .par_bit (par_now)
    );

    // Hold parity and phase of this cycle for use in the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q   <= 1'b0;
            phase_q <= '0;
        end else begin
            par_q        <= par_now;
            phase_q.addr <= addr_phase;
            phase_q.data <= data_phase;
            phase_q.init <= is_initiator;
        end
    end
endmodule

// File: rtl/bpar_err_detect.sv
// Module bpar_err_detect
// Compares the received parity bit with the registered parity of the
// previous cycle and registers gated error reports: a data-phase strobe
// and an address-phase system-error pulse.
// Assumes par_in in this cycle belongs to the phase captured in phase_q.
module bpar_err_detect
    import bpar_pkg::*;
#(
    parameter int unsigned CMD_REG_W = DEF_CMD_REG_W,
    parameter int unsigned PERR_BIT  = DEF_PERR_BIT,
    parameter int unsigned SERR_BIT  = DEF_SERR_BIT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 par_q,
    input  phase_t               phase_q,
    input  logic                 par_in,
    input  logic [CMD_REG_W-1:0] cmd_reg,
    output logic                 perr_out,
    output logic                 serr_out
);
    logic mismatch;
    logic observe;

    // Received bit against the locally computed bit; only when not driving.
    always_comb begin
        mismatch = par_in ^ par_q;
        observe  = ~phase_q.init;
    end

    // Register the gated reports; each lasts one clock per detected error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_out <= 1'b0;
            serr_out <= 1'b0;
        end else begin
            perr_out <= phase_q.data & observe & mismatch & cmd_reg[PERR_BIT];
            serr_out <= phase_q.addr & observe & mismatch & cmd_reg[SERR_BIT];
        end
    end
endmodule

// File: rtl/bus_parity_unit.sv
// Module bus_parity_unit
// Even-parity generation and checking for a multiplexed address/data bus
// with a command/byte-enable field. Drives parity one clock after the
// covered bits when initiator; otherwise checks the incoming bit and
// reports data-phase and address-phase errors two clocks after the phase.
// Assumes the phase qualifiers come from the bus sequencer and are
// mutually exclusive.
module bus_parity_unit
    import bpar_pkg::*;
#(
    parameter int unsigned AD_W      = DEF_AD_W,
    parameter int unsigned CBE_W     = DEF_CBE_W,
    parameter int unsigned CMD_REG_W = DEF_CMD_REG_W,
    parameter int unsigned PERR_BIT  = DEF_PERR_BIT,
    parameter int unsigned SERR_BIT  = DEF_SERR_BIT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AD_W-1:0]      bus_ad,
    input  logic [CBE_W-1:0]     bus_cbe,
    input  logic                 par_in,
    input  logic                 addr_phase,
    input  logic                 data_phase,
    input  logic                 is_initiator,
    input  logic [CMD_REG_W-1:0] cmd_reg,
    output logic                 par_out,
    output logic                 par_oe,
    output logic                 perr_out,
    output logic                 serr_out
);
    logic   par_q;
    phase_t phase_q;

    bpar_capture #(
        .AD_W  (AD_W),
        .CBE_W (CBE_W)
    ) i_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ad       (bus_ad),
        .bus_cbe      (bus_cbe),
        .addr_phase   (addr_phase),
        .data_phase   (data_phase),
        .is_initiator (is_initiator),
        .par_q        (par_q),
        .phase_q      (phase_q)
    );

    bpar_err_detect #(
        .CMD_REG_W (CMD_REG_W),
        .PERR_BIT  (PERR_BIT),
        .SERR_BIT  (SERR_BIT)
    ) i_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_q    (par_q),
        .phase_q  (phase_q),
        .par_in   (par_in),
        .cmd_reg  (cmd_reg),
        .perr_out (perr_out),
        .serr_out (serr_out)
    );

    // Parity drive: valid in the clock after an initiator phase.
    always_comb begin
        par_out = par_q;
        par_oe  = phase_q.init & (phase_q.addr | phase_q.data);
    end
endmodule

// File: rtl/bus_parity_unit_chk.sv
// Module bus_parity_unit_chk
// Temporal checks on the ports of bus_parity_unit, attached by bind.
// Assumes addr_phase and data_phase are never high together.
module bus_parity_unit_chk #(
    parameter int unsigned AD_W      = 32,
    parameter int unsigned CBE_W     = 4,
    parameter int unsigned CMD_REG_W = 16,
    parameter int unsigned PERR_BIT  = 6,
    parameter int unsigned SERR_BIT  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [AD_W-1:0]      bus_ad,
    input logic [CBE_W-1:0]     bus_cbe,
    input logic                 addr_phase,
    input logic                 data_phase,
    input logic                 is_initiator,
    input logic [CMD_REG_W-1:0] cmd_reg,
    input logic                 par_out,
    input logic                 par_oe,
    input logic                 perr_out,
    input logic                 serr_out
);
    assert_even_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> ((^{par_out, $past(bus_cbe), $past(bus_ad)}) == 1'b0));

    assert_oe_after_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> ($past(is_initiator) && ($past(addr_phase) || $past(data_phase))));

    assert_perr_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        perr_out |-> $past(data_phase, 2));

    assert_perr_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        perr_out |-> $past(cmd_reg[PERR_BIT]));

    assert_serr_after_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        serr_out |-> $past(addr_phase, 2));

    assert_serr_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        serr_out |-> $past(cmd_reg[SERR_BIT]));

    assert_no_report_as_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_out || serr_out) |-> !$past(is_initiator, 2));

    assert_not_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(perr_out && serr_out));
endmodule

bind bus_parity_unit bus_parity_unit_chk #(
    .AD_W      (AD_W),
    .CBE_W     (CBE_W),
    .CMD_REG_W (CMD_REG_W),
    .PERR_BIT  (PERR_BIT),
    .SERR_BIT  (SERR_BIT)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ad       (bus_ad),
    .bus_cbe      (bus_cbe),
    .addr_phase   (addr_phase),
    .data_phase   (data_phase),
    .is_initiator (is_initiator),
    .cmd_reg      (cmd_reg),
    .par_out      (par_out),
    .par_oe       (par_oe),
    .perr_out     (perr_out),
    .serr_out     (serr_out)
);

// File: tb/test_bus_parity_unit.sv
// Bench for bus_parity_unit: sweeps phase kind, role, enables, injection
// and 36-bit patterns; expected values come from bit counting.
module test_bus_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_ad;
    logic [3:0]  bus_cbe;
    logic        par_in;
    logic        addr_phase;
    logic        data_phase;
    logic        is_initiator;
    logic [15:0] cmd_reg;
    logic        par_out;
    logic        par_oe;
    logic        perr_out;
    logic        serr_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bus_parity_unit i_bus_parity_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_ad       (bus_ad),
        .bus_cbe      (bus_cbe),
        .par_in       (par_in),
        .addr_phase   (addr_phase),
        .data_phase   (data_phase),
        .is_initiator (is_initiator),
        .cmd_reg      (cmd_reg),
        .par_out      (par_out),
        .par_oe       (par_oe),
        .perr_out     (perr_out),
        .serr_out     (serr_out)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic even_par(input logic [35:0] v);
        return logic'($countones(v) % 2);
    endfunction

    task automatic idle_inputs();
        addr_phase   = 1'b0;
        data_phase   = 1'b0;
        is_initiator = 1'b0;
        par_in       = 1'b0;
        bus_ad       = '0;
        bus_cbe      = '0;
    endtask

    // One isolated case: phase k (0 idle, 1 addr, 2 data), role, enables, inject.
    task automatic run_case(input int k, input bit init, input bit en6,
                            input bit en8, input bit inj, input logic [35:0] pat);
        logic exp_p;
        string rq;
        exp_p = even_par(pat);
        @(negedge clk);
        {bus_cbe, bus_ad} = pat;
        addr_phase   = (k == 1);
        data_phase   = (k == 2);
        is_initiator = init;
        cmd_reg      = 16'h0;
        cmd_reg[6]   = en6;
        cmd_reg[8]   = en8;
        @(negedge clk);                       // cycle T+1
        check("R2", "par_oe", par_oe, init && (k != 0));
        if (par_oe === 1'b1)
            check("R1", "par_out", par_out, exp_p);
        {bus_cbe, bus_ad} = ~pat;
        addr_phase = 1'b0;
        data_phase = 1'b0;
        is_initiator = 1'b0;
        par_in = exp_p ^ inj;
        @(negedge clk);                       // cycle T+2
        rq = init ? "R9" : (inj ? ((k == 2) ? (en6 ? "R3" : "R4") : (en8 ? "R5" : "R6")) : "R8");
        check(rq, "perr_out", perr_out, (k == 2) && !init && inj && en6);
        check(rq, "serr_out", serr_out, (k == 1) && !init && inj && en8);
        idle_inputs();
        @(negedge clk);                       // cycle T+3
        check("R7", "serr_out low after pulse", serr_out, 1'b0);
    endtask

    initial begin
        idle_inputs();
        cmd_reg = 16'h0140;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", "par_oe in reset", par_oe, 1'b0);
        check("R10", "perr_out in reset", perr_out, 1'b0);
        check("R10", "serr_out in reset", serr_out, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 36; i++) begin
            for (int k = 0; k < 3; k++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int e = 0; e < 4; e++) begin
                        for (int j = 0; j < 2; j++) begin
                            logic [35:0] pat;
                            pat = (36'h1 << i) ^ (((i % 3) == 0) ? 36'hA5A53C3CF : 36'h0);
                            run_case(k, r[0], e[0], e[1], j[0], pat);
                        end
                    end
                end
            end
        end

        // Back-to-back address then data phase, both corrupted, as target.
        @(negedge clk);
        cmd_reg = 16'h0140;
        {bus_cbe, bus_ad} = 36'h123456789;
        addr_phase = 1'b1;
        @(negedge clk);                       // addr T+1, data T
        par_in = even_par(36'h123456789) ^ 1'b1;
        addr_phase = 1'b0;
        data_phase = 1'b1;
        {bus_cbe, bus_ad} = 36'hF0F0F0F01;
        @(negedge clk);                       // addr T+2, data T+1
        check("R5", "serr_out back-to-back", serr_out, 1'b1);
        check("R3", "perr_out not yet", perr_out, 1'b0);
        par_in = even_par(36'hF0F0F0F01) ^ 1'b1;
        data_phase = 1'b0;
        @(negedge clk);                       // addr T+3, data T+2
        check("R7", "serr_out one clock", serr_out, 1'b0);
        check("R3", "perr_out back-to-back", perr_out, 1'b1);
        idle_inputs();
        @(negedge clk);
        check("R3", "perr_out one clock", perr_out, 1'b0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule